// File: doc/BRIEF.md
# Hysteretic Boost Burst Controller

This block is the digital half of a hysteretic (bang-bang) boost converter. An analog comparator reports whether the high-voltage rail sits below its reference. While it does, the controller fires a train of fixed-width switch pulses. It stops once the comparator reports the rail above the reference again. A 4-bit setpoint code is registered and handed to the external reference DAC that sets the comparator threshold.

Each pulse covers one whole switching period: a fixed on-time, then an off-time, as suits discontinuous conduction. The length of each period is taken from a 16-entry table. A maximal-length 4-bit LFSR picks the entry, so the switching frequency hops pseudo-randomly inside a 0.8 MHz to 4 MHz band and averages 2 MHz from a 48 MHz system clock. This spreads the emitted spectrum.

Bursts begin and end only on period boundaries. A shutdown input overrides everything: the switch gate goes low at once, and the driver output enable is deasserted so that the external drivers go high-impedance.

Top module: `boost_burst_ctrl`

## Requirements
- R1: `vref_code` equals the value of `vref_sel` one clock earlier; it is all zeros in reset.
- R2: `rail_low` passes through two synchronizer flops, so from idle the first `sw_gate` high appears in the third cycle after `rail_low` is raised, with the input driven between clock edges.
- R3: Every pulse that shutdown does not cut short holds `sw_gate` high for exactly 6 consecutive cycles, and `sw_gate` is high only while `burst_active` is high.
- R4: The period in cycles for LFSR state s is: 1→12, 2→12, 3→13, 4→14, 5→15, 6→16, 7→17, 8→18, 9→20, 10→22, 11→24, 12→28, 13→34, 14→55, 15→60. The LFSR shifts left with new LSB = bit3 XOR bit2, is seeded with 1, and advances once at the end of each completed period. The first pulse after reset therefore uses state 1, the next state 2, then 4, 9, 3, 6, 13, and so on.
- R5: Over the 15 pulses of one full LFSR cycle, the periods sum to 360 cycles, which is a mean of 2 MHz at 48 MHz.
- R6: In a continuous burst, the spacing between successive rising edges of `sw_gate` lies between 12 and 60 cycles inclusive.
- R7: A burst ends only at the end of a full period. If `rail_low` falls mid-period, `burst_active` stays high until that period completes.
- R8: While `shutdown` is high, `sw_gate` and `drv_oe` are both low in the same cycle. `drv_oe` is high whenever `shutdown` is low.
- R9: `shutdown` clears `burst_active` at the next clock edge. A pulse it aborts does not advance the LFSR. After release with the rail still low, the next pulse starts one edge later.
- R10: Asynchronous reset drives `sw_gate`, `burst_active` and `vref_code` low and reseeds the LFSR to 1.
- R11: No burst starts unless `rail_low` was high three clock edges before `burst_active` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown | input | 1 | Stops switching and releases the drivers |
| rail_low | input | 1 | Comparator output, high when the rail is below the reference |
| vref_sel | input | 4 | Setpoint code requested for the reference DAC |
| vref_code | output | 4 | Registered setpoint code driven to the DAC |
| sw_gate | output | 1 | Switch gate pulse |
| drv_oe | output | 1 | Driver output enable; low means high-impedance |
| burst_active | output | 1 | High while a switching period is in progress |

## Verification
The properties assume that `rail_low` and `shutdown` change only between clock edges and hold their level across an edge. This is why the start-cause check can look back a fixed three edges through the synchronizer. The bench drives every input one nanosecond after a falling edge and samples at the same point, so no input ever moves near a rising edge. The period and on-time properties also assume that an abort occurs only through `shutdown`. For that reason the bench changes `rail_low` mid-period only to test boundary stopping, and it never does so together with reset.

// File: rtl/bb_pkg.sv
`timescale 1ns/1ps
package bb_pkg;

   localparam int unsigned IDX_W      = 4;
   localparam int unsigned PERIOD_MIN = 12;
   localparam int unsigned PERIOD_MAX = 60;
   localparam int unsigned PERIOD_NOM = 24;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } burst_state_e;

   // Spread table: mean over states 1..15 is 360/15 = 24 cycles.
   function automatic int unsigned spread_period(input logic [IDX_W-1:0] idx);
      case (idx)
         4'd1:    return 12;
         4'd2:    return 12;
         4'd3:    return 13;
         4'd4:    return 14;
         4'd5:    return 15;
         4'd6:    return 16;
         4'd7:    return 17;
         4'd8:    return 18;
         4'd9:    return 20;
         4'd10:   return 22;
         4'd11:   return 24;
         4'd12:   return 28;
         4'd13:   return 34;
         4'd14:   return 55;
         4'd15:   return 60;
         default: return PERIOD_NOM;
      endcase
   endfunction

endpackage

// File: rtl/bb_sync.sv
`timescale 1ns/1ps
module bb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q[gi] <= 1'b0;
            end else begin
               chain_q[gi] <= (gi == 0) ? d_async : chain_q[(gi == 0) ? 0 : gi-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bb_lfsr.sv
`timescale 1ns/1ps
module bb_lfsr #(
   parameter int          W    = 4,
   parameter logic [W-1:0] SEED = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         advance,
   output logic [W-1:0] state,
   output logic [W-1:0] state_next
);
   logic fb;

   generate
      if (W == 4) begin : g_w4
         assign fb = state[3] ^ state[2];
      end else if (W == 5) begin : g_w5
         assign fb = state[4] ^ state[2];
      end else if (W == 6) begin : g_w6
         assign fb = state[5] ^ state[4];
      end else if (W == 7) begin : g_w7
         assign fb = state[6] ^ state[5];
      end else begin : g_w8
         assign fb = state[W-1] ^ state[W-3] ^ state[W-4] ^ state[W-5];
      end
   endgenerate

   assign state_next = {state[W-2:0], fb};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEED;
      end else if (advance) begin
         state <= state_next;
      end
   end
endmodule

// File: rtl/bb_period_rom.sv
`timescale 1ns/1ps
module bb_period_rom
   import bb_pkg::*;
#(
   parameter int CNT_W  = 6,
   parameter bit SPREAD = 1'b1
) (
   input  logic [IDX_W-1:0] idx,
   output logic [CNT_W-1:0] period
);
   generate
      if (SPREAD) begin : g_spread
         assign period = CNT_W'(spread_period(idx));
      end else begin : g_fixed
         logic [IDX_W-1:0] unused_idx;
         assign unused_idx = idx;
         assign period     = CNT_W'(PERIOD_NOM);
      end
   endgenerate
endmodule

// File: rtl/bb_pulse_fsm.sv
`timescale 1ns/1ps
module bb_pulse_fsm
   import bb_pkg::*;
#(
   parameter int CNT_W     = 6,
   parameter int ON_CYCLES = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shutdown,
   input  logic             rail_low_s,
   input  logic [CNT_W-1:0] period_now,
   input  logic [CNT_W-1:0] period_nxt,
   output logic             sw_gate,
   output logic             running,
   output logic             advance
);
   localparam logic [CNT_W-1:0] ON_C = CNT_W'(ON_CYCLES);

   burst_state_e     state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_q;
   logic             want;
   logic             last;

   assign want    = rail_low_s && !shutdown;
   assign last    = (state_q == ST_RUN) && (cnt_q == per_q - 1'b1);
   assign advance = last && !shutdown;
   assign running = (state_q == ST_RUN);
   assign sw_gate = running && (cnt_q < ON_C) && !shutdown;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         per_q   <= '0;
      end else if (shutdown) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (want) begin
                  state_q <= ST_RUN;
                  cnt_q   <= '0;
                  per_q   <= period_now;
               end
            end
            default: begin
               if (last) begin
                  cnt_q <= '0;
                  if (want) begin
                     per_q <= period_nxt;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/boost_burst_ctrl.sv
`timescale 1ns/1ps
module boost_burst_ctrl
   import bb_pkg::*;
#(
   parameter int CODE_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int LFSR_W      = 4,
   parameter int LFSR_SEED   = 1,
   parameter int ON_CYCLES   = 6,
   parameter bit SPREAD_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shutdown,
   input  logic              rail_low,
   input  logic [CODE_W-1:0] vref_sel,
   output logic [CODE_W-1:0] vref_code,
   output logic              sw_gate,
   output logic              drv_oe,
   output logic              burst_active
);
   localparam int CNT_W = $clog2(PERIOD_MAX + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (LFSR_W < 4 || LFSR_W > 8) begin : g_bad_lfsr
         $error("LFSR_W must lie in 4..8");
      end
      if (LFSR_SEED == 0) begin : g_bad_seed
         $error("LFSR_SEED must be nonzero");
      end
      if (ON_CYCLES < 1 || ON_CYCLES >= PERIOD_MIN) begin : g_bad_on
         $error("ON_CYCLES must be shorter than the shortest period");
      end
   endgenerate

   logic              rail_low_s;
   logic [LFSR_W-1:0] lfsr_q;
   logic [LFSR_W-1:0] lfsr_n;
   logic [CNT_W-1:0]  period_now;
   logic [CNT_W-1:0]  period_nxt;
   logic              advance;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vref_code <= '0;
      end else begin
         vref_code <= vref_sel;
      end
   end

   assign drv_oe = !shutdown;

   bb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (rail_low),
      .q_sync  (rail_low_s)
   );

   bb_lfsr #(.W(LFSR_W), .SEED(LFSR_W'(LFSR_SEED))) u_lfsr (
      .clk        (clk),
      .rst_n      (rst_n),
      .advance    (advance),
      .state      (lfsr_q),
      .state_next (lfsr_n)
   );

   bb_period_rom #(.CNT_W(CNT_W), .SPREAD(SPREAD_EN)) u_rom_now (
      .idx    (lfsr_q[IDX_W-1:0]),
      .period (period_now)
   );

   bb_period_rom #(.CNT_W(CNT_W), .SPREAD(SPREAD_EN)) u_rom_nxt (
      .idx    (lfsr_n[IDX_W-1:0]),
      .period (period_nxt)
   );

   bb_pulse_fsm #(.CNT_W(CNT_W), .ON_CYCLES(ON_CYCLES)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .shutdown   (shutdown),
      .rail_low_s (rail_low_s),
      .period_now (period_now),
      .period_nxt (period_nxt),
      .sw_gate    (sw_gate),
      .running    (burst_active),
      .advance    (advance)
   );
endmodule

// File: rtl/boost_burst_chk.sv
`timescale 1ns/1ps
module boost_burst_chk
   import bb_pkg::*;
#(
   parameter int CODE_W    = 4,
   parameter int ON_CYCLES = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              shutdown,
   input logic              rail_low,
   input logic [CODE_W-1:0] vref_sel,
   input logic [CODE_W-1:0] vref_code,
   input logic              sw_gate,
   input logic              drv_oe,
   input logic              burst_active
);
   logic       live;
   logic       sw_prev;
   logic       burst_prev;
   logic       sd_prev;
   logic       seen;
   logic [7:0] since;
   logic [7:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live       <= 1'b0;
         sw_prev    <= 1'b0;
         burst_prev <= 1'b0;
         sd_prev    <= 1'b0;
         seen       <= 1'b0;
         since      <= '0;
         hi_cnt     <= '0;
      end else begin
         live       <= 1'b1;
         sw_prev    <= sw_gate;
         burst_prev <= burst_active;
         sd_prev    <= shutdown;
         hi_cnt     <= sw_gate ? hi_cnt + 8'd1 : 8'd0;
         if (sw_gate && !sw_prev)  since <= 8'd1;
         else if (since != 8'hFF)  since <= since + 8'd1;
         if (!burst_active)        seen <= 1'b0;
         else if (sw_gate && !sw_prev) seen <= 1'b1;
      end
   end

   p_vref_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> vref_code == $past(vref_sel));

   p_on_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (live && sw_prev && !sw_gate && !shutdown) |-> hi_cnt == 8'(ON_CYCLES));

   p_gate_in_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sw_gate |-> burst_active);

   p_period_band_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_gate && !sw_prev && seen) |->
         (since >= 8'(PERIOD_MIN) && since <= 8'(PERIOD_MAX)));

   p_stop_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (live && burst_prev && !burst_active && !sd_prev) |->
         (since >= 8'(PERIOD_MIN) && since <= 8'(PERIOD_MAX)));

   p_sd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |-> (!sw_gate && !drv_oe));

   p_sd_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |=> !burst_active);

   p_start_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (live && burst_active && !burst_prev) |-> $past(rail_low, 3));

   always @(negedge clk) begin
      if (!rst_n) begin
         p_reset_state_r10: assert (!sw_gate && !burst_active && vref_code == '0);
      end
   end
endmodule

bind boost_burst_ctrl boost_burst_chk #(.CODE_W(CODE_W), .ON_CYCLES(ON_CYCLES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .shutdown     (shutdown),
   .rail_low     (rail_low),
   .vref_sel     (vref_sel),
   .vref_code    (vref_code),
   .sw_gate      (sw_gate),
   .drv_oe       (drv_oe),
   .burst_active (burst_active)
);

// File: tb/test_boost_burst_ctrl.sv
`timescale 1ns/1ps
module test_boost_burst_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       shutdown = 1'b0;
   logic       rail_low = 1'b0;
   logic [3:0] vref_sel = 4'd0;
   logic [3:0] vref_code;
   logic       sw_gate;
   logic       drv_oe;
   logic       burst_active;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   // Expected periods from seed 1: states 1,2,4,9,3,6,13,10,5,11,7,15,14,12,8,1
   localparam int EXP_PER [16] = '{12, 12, 14, 20, 13, 16, 34, 22,
                                   15, 24, 17, 60, 55, 28, 18, 12};

   always #2.5 clk = ~clk;

   boost_burst_ctrl i_boost_burst_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .shutdown     (shutdown),
      .rail_low     (rail_low),
      .vref_sel     (vref_sel),
      .vref_code    (vref_code),
      .sw_gate      (sw_gate),
      .drv_oe       (drv_oe),
      .burst_active (burst_active)
   );

   task automatic nxt();
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   // Called on the sample where sw_gate has just risen; returns at the next rise.
   task automatic measure(output int hi, output int per);
      int guard;
      hi = 0; per = 0; guard = 0;
      while (sw_gate && guard < 100) begin hi++; per++; guard++; nxt(); end
      while (!sw_gate && guard < 100) begin per++; guard++; nxt(); end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int hi, per, sum, k, bad;
      nxt();
      // R10: reset state
      chk("R10 reset sw_gate", sw_gate, 0);
      chk("R10 reset burst_active", burst_active, 0);
      chk("R10 reset vref_code", vref_code, 0);
      chk("R8 drv_oe high without shutdown", drv_oe, 1);
      nxt();
      rst_n = 1'b1;
      nxt();

      // R1: setpoint registered through
      vref_sel = 4'hA; nxt();
      chk("R1 vref_code A", vref_code, 10);
      vref_sel = 4'h5; nxt();
      chk("R1 vref_code 5", vref_code, 5);

      // R2: start latency through the synchronizer
      rail_low = 1'b1;
      nxt(); nxt();
      chk("R2 gate still low after two edges", sw_gate, 0);
      nxt();
      chk("R2 gate high on third edge", sw_gate, 1);

      // R3..R6: walk the expected period table
      sum = 0;
      for (int i = 0; i < 16; i++) begin
         measure(hi, per);
         chk($sformatf("R3 on-time pulse %0d", i), hi, 6);
         chk($sformatf("R4 period pulse %0d", i), per, EXP_PER[i]);
         chk($sformatf("R6 band pulse %0d", i), int'(per >= 12 && per <= 60), 1);
         if (i < 15) sum += per;
      end
      chk("R5 sum of one LFSR cycle", sum, 360);

      // R7: rail drops mid-period (pulse with period 12 just started)
      rail_low = 1'b0;
      k = 0;
      while (burst_active && k < 100) begin k++; nxt(); end
      chk("R7 burst held for full period", k, 12);
      // R11: no new burst while rail is not low
      bad = 0;
      for (int i = 0; i < 10; i++) begin
         if (burst_active || sw_gate) bad++;
         nxt();
      end
      chk("R11 idle while rail high", bad, 0);

      // R8/R9: shutdown mid-pulse (next state 4, period 14)
      rail_low = 1'b1;
      nxt(); nxt(); nxt();
      chk("R2 restart latency", sw_gate, 1);
      nxt(); nxt();
      shutdown = 1'b1;
      #0.5;
      chk("R8 gate low in shutdown", sw_gate, 0);
      chk("R8 drv_oe low in shutdown", drv_oe, 0);
      nxt();
      chk("R9 burst cleared after shutdown", burst_active, 0);
      bad = 0;
      for (int i = 0; i < 6; i++) begin
         if (sw_gate || burst_active || drv_oe) bad++;
         nxt();
      end
      chk("R8 quiet during shutdown", bad, 0);
      shutdown = 1'b0;
      nxt();
      chk("R9 resume one edge after release", sw_gate, 1);
      measure(hi, per);
      chk("R9 aborted pulse did not advance LFSR", per, 14);
      measure(hi, per);
      chk("R4 period after resume", per, 20);

      // R10: reset mid-burst reseeds
      rst_n = 1'b0;
      #0.5;
      chk("R10 async reset gate", sw_gate, 0);
      chk("R10 async reset burst", burst_active, 0);
      chk("R10 async reset vref_code", vref_code, 0);
      nxt(); nxt();
      rst_n = 1'b1;
      nxt(); nxt(); nxt();
      chk("R10 start after reset", sw_gate, 1);
      measure(hi, per);
      chk("R10 reseeded first period", per, 12);

      finish_run();
   end
endmodule